// File: doc/BRIEF.md
# Scan Test Wrapper for Memory Macro Input Registers

This block holds the registered inputs of a memory macro (address, enable, read/write select, bit mask and write data) and turns them into scan chains for test. In normal operation every register loads from its pin on each rising clock edge and feeds the macro core. The scan control input is ignored in this mode.

When test mode is raised, the core enable is forced low, so no read or write takes place. The scan control then chooses between capturing the pins and shifting the chains. There are three chains:

- The address/control chain has its own serial input and its own serial output.
- The left data chain covers the upper half of the data bus and has its own serial input.
- The right data chain covers the lower half of the data bus and has its own serial input.

The data chains have no scan-out pin. They are observed through the data output bus, which in test mode shows the data registers in parallel instead of the macro's read data.

Top module: `scan_wrap`

## Requirements
- R1: While reset is high, every scan register is cleared, so scan_out_ac, core_addr, core_rw, core_mask, core_wdata are 0 and dout is 0 when test mode is high.
- R2: With tm low, every register loads its pin on each rising edge and the value appears on the core outputs after that edge; scan_en has no effect.
- R3: While tm is high, core_en is 0 whatever the enable register holds.
- R4: With tm and scan_en high, the address/control chain shifts one place per edge. The serial input enters address bit 0 and moves up through address bits 0..31, then enable (position 32), then read/write (position 33), then mask bits 0..31 (positions 34..65). Position 65 (mask bit 31) drives scan_out_ac.
- R5: With tm high and scan_en low, the address/control chain captures the pins. A following run of shifts presents positions 65, 64, ... 0 on scan_out_ac, one per edge.
- R6: With tm and scan_en high, the left data chain enters at data bit 31 from scan_in_dl and moves down to bit 16. After 16 shifts, the bit shifted in at step s (from 0) sits at dout bit 16+s.
- R7: With tm and scan_en high, the right data chain enters at data bit 15 from scan_in_dr and moves down to bit 0, independent of the left chain. After 16 shifts, the bit shifted in at step s sits at dout bit s.
- R8: dout equals core_rdata while tm is low, and equals the data registers while tm is high.
- R9: With tm high and scan_en low, the data registers capture data_in on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tm | input | 1 | Test mode select |
| scan_en | input | 1 | Shift (1) or capture (0) in test mode |
| addr_in | input | 32 | Address pins |
| en_in | input | 1 | Access enable pin |
| rw_in | input | 1 | Read (1) / write (0) pin |
| mask_in | input | 32 | Per-bit write mask pins |
| data_in | input | 32 | Write data pins |
| scan_in_ac | input | 1 | Serial input of address/control chain |
| scan_in_dl | input | 1 | Serial input of left data chain |
| scan_in_dr | input | 1 | Serial input of right data chain |
| core_rdata | input | 32 | Read data from the macro core |
| core_addr | output | 32 | Registered address to core |
| core_en | output | 1 | Registered enable to core, blocked in test mode |
| core_rw | output | 1 | Registered read/write select to core |
| core_mask | output | 32 | Registered mask to core |
| core_wdata | output | 32 | Registered write data to core |
| dout | output | 32 | Read data, or data chain registers in test mode |
| scan_out_ac | output | 1 | Serial output of address/control chain |

## Verification
The shift properties compare each register with its chain neighbour one edge earlier. They therefore assume that tm holds its value across that edge, so that dout shows the data registers in both cycles. The stimulus changes tm and scan_en only between whole shift or capture phases and never in the middle of a run. The capture properties assume that reset is low at the capturing edge, and the stimulus raises reset only at the start.

// File: rtl/scan_wrap.sv
module scan_wrap #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tm,
  input  logic          scan_en,
  input  logic [AW-1:0] addr_in,
  input  logic          en_in,
  input  logic          rw_in,
  input  logic [DW-1:0] mask_in,
  input  logic [DW-1:0] data_in,
  input  logic          scan_in_ac,
  input  logic          scan_in_dl,
  input  logic          scan_in_dr,
  input  logic [DW-1:0] core_rdata,
  output logic [AW-1:0] core_addr,
  output logic          core_en,
  output logic          core_rw,
  output logic [DW-1:0] core_mask,
  output logic [DW-1:0] core_wdata,
  output logic [DW-1:0] dout,
  output logic          scan_out_ac
);
  localparam int CW = AW + 2 + DW;
  localparam int HW = DW / 2;

  logic [CW-1:0] ac_q;
  logic [DW-1:0] d_q;
  logic          shift;

  assign shift = tm & scan_en;

  always_ff @(posedge clk) begin
    if (rst)        ac_q <= '0;
    else if (shift) ac_q <= {ac_q[CW-2:0], scan_in_ac};
    else            ac_q <= {mask_in, rw_in, en_in, addr_in};
  end

  always_ff @(posedge clk) begin
    if (rst)        d_q[DW-1:HW] <= '0;
    else if (shift) d_q[DW-1:HW] <= {scan_in_dl, d_q[DW-1:HW+1]};
    else            d_q[DW-1:HW] <= data_in[DW-1:HW];
  end

  always_ff @(posedge clk) begin
    if (rst)        d_q[HW-1:0] <= '0;
    else if (shift) d_q[HW-1:0] <= {scan_in_dr, d_q[HW-1:1]};
    else            d_q[HW-1:0] <= data_in[HW-1:0];
  end

  assign core_addr   = ac_q[AW-1:0];
  assign core_en     = ac_q[AW] & ~tm;
  assign core_rw     = ac_q[AW+1];
  assign core_mask   = ac_q[CW-1:AW+2];
  assign core_wdata  = d_q;
  assign dout        = tm ? d_q : core_rdata;
  assign scan_out_ac = ac_q[CW-1];
endmodule

// File: rtl/scan_wrap_chk.sv
module scan_wrap_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tm,
  input logic          scan_en,
  input logic [AW-1:0] addr_in,
  input logic          en_in,
  input logic          rw_in,
  input logic [DW-1:0] mask_in,
  input logic [DW-1:0] data_in,
  input logic          scan_in_ac,
  input logic          scan_in_dl,
  input logic          scan_in_dr,
  input logic [AW-1:0] core_addr,
  input logic          core_rw,
  input logic [DW-1:0] core_mask,
  input logic [DW-1:0] dout,
  input logic          scan_out_ac
);
  localparam int HW = DW / 2;

  p_norm_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!tm && !rst) |=> (core_addr == $past(addr_in) && core_rw == $past(rw_in)
                       && core_mask == $past(mask_in)));

  p_ac_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (tm && scan_en && !rst) |=> (core_addr[0] == $past(scan_in_ac)
                                 && core_mask[0] == $past(core_rw)
                                 && scan_out_ac == $past(core_mask[DW-2])));

  p_left_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (tm && scan_en && !rst) |=> (tm -> (dout[DW-1] == $past(scan_in_dl)
                                        && dout[HW] == $past(dout[HW+1]))));

  p_right_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (tm && scan_en && !rst) |=> (tm -> (dout[HW-1] == $past(scan_in_dr)
                                        && dout[0] == $past(dout[1]))));

  p_tm_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (tm && !scan_en && !rst) |=> (tm -> dout == $past(data_in)));
endmodule

bind scan_wrap scan_wrap_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_scan_wrap.sv
`timescale 1ns/1ps
module sim_scan_wrap;
  logic clk = 0, rst = 1, tm = 1, scan_en = 0;
  logic [31:0] addr_in = 0, mask_in = 0, data_in = 0, core_rdata = 0;
  logic en_in = 0, rw_in = 0, scan_in_ac = 0, scan_in_dl = 0, scan_in_dr = 0;
  logic [31:0] core_addr, core_mask, core_wdata, dout;
  logic core_en, core_rw, scan_out_ac;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scan_wrap u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit fa(int k); return ((k * 7 + 3) % 5) < 2; endfunction
  function automatic bit fl(int k); return ((k * 3 + 1) % 4) == 0; endfunction
  function automatic bit fr(int k); return (k % 3) != 1; endfunction

  function automatic bit acpos(int p, logic [31:0] a, logic e, logic w, logic [31:0] m);
    if (p >= 34) return m[p-34];
    if (p == 33) return w;
    if (p == 32) return e;
    return a[p];
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, m, d;
    addr_in = 32'hFFFF_FFFF; mask_in = 32'hFFFF_FFFF; data_in = 32'hFFFF_FFFF;
    en_in = 1; rw_in = 1;
    step(); step();
    chk("R1 dout", dout, 0);
    chk("R1 scan_out", {31'd0, scan_out_ac}, 0);
    chk("R1 addr", core_addr, 0);
    chk("R1 mask", core_mask, 0);
    chk("R1 wdata", core_wdata, 0);
    chk("R1 rw", {31'd0, core_rw}, 0);
    rst = 0; tm = 0; scan_en = 1;
    for (int i = 0; i < 16; i++) begin
      a = 32'h3000_0004 ^ (i * 32'h1357_9BDF);
      m = ~a ^ (32'h1 << i);
      d = a + 32'h0F0F_1234 * i;
      addr_in = a; mask_in = m; data_in = d; en_in = i[0]; rw_in = i[1];
      core_rdata = ~d;
      step();
      chk("R2 addr", core_addr, a);
      chk("R2 mask", core_mask, m);
      chk("R2 wdata", core_wdata, d);
      chk("R2 en", {31'd0, core_en}, {31'd0, i[0]});
      chk("R2 rw", {31'd0, core_rw}, {31'd0, i[1]});
      chk("R8 dout normal", dout, ~d);
    end
    tm = 1; scan_en = 0; en_in = 1; rw_in = 1;
    a = 32'hA5C3_0F96; m = 32'h8000_0001 | 32'h1234_5600; d = 32'hDEAD_BEEF;
    addr_in = a; mask_in = m; data_in = d; core_rdata = 32'h0;
    step();
    chk("R3 core_en", {31'd0, core_en}, 0);
    chk("R9 capture", dout, d);
    chk("R8 dout test", dout, core_wdata);
    chk("R5 capture addr", core_addr, a);
    scan_en = 1;
    for (int k = 0; k < 66; k++) begin
      chk("R5 scan_out", {31'd0, scan_out_ac}, {31'd0, acpos(65 - k, a, 1'b1, 1'b1, m)});
      scan_in_ac = fa(k);
      scan_in_dl = fl(k); scan_in_dr = fr(k);
      step();
      if (k == 15) begin
        for (int s = 0; s < 16; s++) begin
          chk("R6 left", {31'd0, dout[16+s]}, {31'd0, fl(s)});
          chk("R7 right", {31'd0, dout[s]}, {31'd0, fr(s)});
        end
      end
    end
    for (int i = 0; i < 32; i++) begin
      chk("R4 addr", {31'd0, core_addr[i]}, {31'd0, fa(65 - i)});
      chk("R4 mask", {31'd0, core_mask[i]}, {31'd0, fa(31 - i)});
    end
    chk("R4 rw", {31'd0, core_rw}, {31'd0, fa(32)});
    chk("R4 scan_out", {31'd0, scan_out_ac}, {31'd0, fa(0)});
    chk("R3 core_en shift", {31'd0, core_en}, 0);
    tm = 0;
    step();
    chk("R3 core_en release", {31'd0, core_en}, 1);
    chk("R2 after test", core_addr, a);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule